// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block turns memory requests from a small 8-bit processor core into timed external bus cycles. The external bus has one shared byte lane for the low address byte and the data, and a separate set of high address lines. Every bus cycle lasts five input clocks. In the first part of a cycle the sequencer drives the low address byte on the shared lane and pulses an address strobe. An external latch captures that byte when the strobe falls. In the second part a data strobe is raised. During the data strobe the lane either carries write data or is released so that a read value can be sampled.

A direction line, the five high address bits and an opcode-fetch indicator are held for the whole cycle. The strobes keep running when the core has nothing to transfer. Such a cycle is a dummy read of the last address. Internal-access cycles also run the strobes, but they leave the lane released. A hold input, used for wait and stop modes, parks the bus at the end of the current cycle. When hold is removed, the sequencer restarts on the next clock.

Top module: `mbus_seq`

## Requirements
- R1: A running bus cycle is exactly five clocks long, numbered phase 0 to 4. `bus_as` is high in phases 0 and 1, `bus_ds` is high in phases 3 and 4, and the two strobes are never high together.
- R2: In phases 0 to 2, `lane_oe` is 1 and `lane_out` equals `req_addr[7:0]` of the cycle's request. The lane value does not change on the clock where `bus_as` falls.
- R3: In a write cycle that is not internal, `lane_out` equals the write data and `lane_oe` is 1 during phases 3 and 4, and `bus_rw` is 0 for the whole cycle.
- R4: In an external read, the lane is released (`lane_oe`=0) while `bus_ds` is high. `lane_in` is sampled on the clock edge where `bus_ds` falls, and it appears on `rd_data` together with a one-clock `rd_valid` pulse.
- R5: `bus_rw` is 1 in read, dummy and parked cycles, and it is 1 in reset.
- R6: `addr_hi` equals `req_addr[12:8]` of the cycle's request. `addr_hi` and `bus_rw` are stable while `bus_ds` is high.
- R7: `bus_li` is 1 for the whole cycle of a read whose request has `req_fetch`=1 and `req_intr`=0. It is 0 for writes, for interrupt-sequence requests and for dummy cycles.
- R8: An internal access (`req_internal`=1) runs both strobes and `bus_rw` as normal. It keeps the lane released in phases 3 and 4 and produces no `rd_valid`.
- R9: A cycle that starts with `req_valid`=0 is a dummy read. It drives the previous cycle's address, keeps `bus_rw`=1 and `bus_li`=0, and produces no `rd_valid` and no `req_taken`.
- R10: `hold` is looked at only on the clock that ends a cycle, and a cycle already under way finishes. While parked, `bus_as`, `bus_ds`, `lane_oe` and `bus_li` are 0 and `bus_rw` is 1. One clock after `hold` drops, a new cycle is in phase 0.
- R11: `req_taken` is high for exactly the phase-0 clock of the cycle that accepted the request. A request is accepted on the clock edge that starts a cycle while `req_valid` is 1.
- R12: During reset, `bus_as`, `bus_ds`, `bus_li`, `lane_oe`, `rd_valid` and `req_taken` are 0 and `bus_rw` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, five per bus cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| hold | input | 1 | Wait/stop: park the bus after the current cycle |
| req_valid | input | 1 | Core has a transfer for the next cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | Request is an opcode fetch |
| req_intr | input | 1 | Request belongs to an interrupt sequence |
| req_internal | input | 1 | Target is on-chip memory or a register |
| req_addr | input | 13 | Transfer address |
| req_wdata | input | 8 | Write data |
| req_taken | output | 1 | Request accepted; high in phase 0 |
| bus_as | output | 1 | Address strobe |
| bus_ds | output | 1 | Data strobe |
| bus_rw | output | 1 | Direction: 1 read, 0 write |
| bus_li | output | 1 | Opcode-fetch indicator |
| lane_out | output | 8 | Shared lane drive value |
| lane_oe | output | 1 | Shared lane output enable |
| lane_in | input | 8 | Shared lane sampled value |
| addr_hi | output | 5 | High address bits 12:8 |
| rd_data | output | 8 | Last captured read byte |
| rd_valid | output | 1 | One-clock pulse when `rd_data` is updated |

## Verification
Several properties are checked on every clock: that the strobes never overlap, the length of each data-strobe pulse, that the lane is driven under the address strobe and held while that strobe falls, that the lane is released during read data phases, that direction and high address stay stable under the data strobe, that the fetch indicator appears only with reads, and how the capture and acceptance pulses line up with the strobe edges. Other points can only be shown by the bench's scenarios, because they depend on the values requested: the exact phase positions, the data values on the lane and on `rd_data`, the address repeated by dummy cycles, and the timing of parking and restarting under `hold`. The bench covers these by sweeping every combination of direction, fetch, interrupt and internal flags over computed addresses and data.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    localparam int unsigned ADDR_W = 13;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned HI_W   = ADDR_W - DATA_W;

    // Transfer carried by the current bus cycle
    typedef struct packed {
        logic              live;      // came from a core request (not dummy)
        logic              write;
        logic              fetch;     // qualified opcode fetch
        logic              internal;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } xfer_t;

    // Registered pin image
    typedef struct packed {
        logic              as_p;
        logic              ds_p;
        logic              rw_p;
        logic              li_p;
        logic              oe_p;
        logic [DATA_W-1:0] lane;
        logic [HI_W-1:0]   hi;
        logic              taken;
    } pins_t;

endpackage

// File: rtl/mbus_phase.sv
module mbus_phase #(
    parameter int unsigned CYC_LEN = 5,
    localparam int unsigned PH_W   = (CYC_LEN > 1) ? $clog2(CYC_LEN) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold,
    output logic [PH_W-1:0] ph_next,
    output logic            run_next,
    output logic            start_next,
    output logic            last_now
);

    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CYC_LEN - 1);

    typedef struct packed {
        logic [PH_W-1:0] ph;
        logic            run;
    } ph_state_t;

    ph_state_t st_d, st_q;
    logic      edge_end;

    always_comb begin
        st_d       = st_q;
        start_next = 1'b0;
        edge_end   = !st_q.run || (st_q.ph == PH_LAST);
        if (edge_end) begin
            st_d.ph = '0;
            if (hold) begin
                st_d.run = 1'b0;
            end else begin
                st_d.run   = 1'b1;
                start_next = 1'b1;
            end
        end else begin
            st_d.ph = st_q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ph_next  = st_d.ph;
    assign run_next = st_d.run;
    assign last_now = st_q.run && (st_q.ph == PH_LAST);

endmodule

// File: rtl/mbus_rdcap.sv
module mbus_rdcap #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [DATA_W-1:0] lane_in,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              vld;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d     = cap_q;
        cap_d.vld = fire;
        if (fire) begin
            cap_d.data = lane_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign rd_data  = cap_q.data;
    assign rd_valid = cap_q.vld;

endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
    import mbus_pkg::*;
#(
    parameter int unsigned CYC_LEN  = 5,
    parameter int unsigned AS_LAST  = 1,
    parameter int unsigned ADR_LAST = 2,
    parameter int unsigned DS_FIRST = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_fetch,
    input  logic              req_intr,
    input  logic              req_internal,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_taken,
    output logic              bus_as,
    output logic              bus_ds,
    output logic              bus_rw,
    output logic              bus_li,
    output logic [DATA_W-1:0] lane_out,
    output logic              lane_oe,
    input  logic [DATA_W-1:0] lane_in,
    output logic [HI_W-1:0]   addr_hi,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    localparam int unsigned PH_W = (CYC_LEN > 1) ? $clog2(CYC_LEN) : 1;
    localparam logic [PH_W-1:0] AS_END  = PH_W'(AS_LAST);
    localparam logic [PH_W-1:0] ADR_END = PH_W'(ADR_LAST);
    localparam logic [PH_W-1:0] DS_BEG  = PH_W'(DS_FIRST);

    logic [PH_W-1:0] ph_d;
    logic            run_d;
    logic            start_d;
    logic            last_q;
    logic            cap_fire;

    xfer_t cur_d, cur_q;
    pins_t pins_d, pins_q;

    mbus_phase #(.CYC_LEN(CYC_LEN)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (hold),
        .ph_next    (ph_d),
        .run_next   (run_d),
        .start_next (start_d),
        .last_now   (last_q)
    );

    // Next-state logic for the transfer latch and the pin image
    always_comb begin
        cur_d = cur_q;
        if (start_d) begin
            if (req_valid) begin
                cur_d.live     = 1'b1;
                cur_d.write    = req_write;
                cur_d.fetch    = req_fetch && !req_write && !req_intr;
                cur_d.internal = req_internal;
                cur_d.addr     = req_addr;
                cur_d.wdata    = req_wdata;
            end else begin
                cur_d.live     = 1'b0;
                cur_d.write    = 1'b0;
                cur_d.fetch    = 1'b0;
                cur_d.internal = 1'b0;
            end
        end

        pins_d       = '0;
        pins_d.rw_p  = 1'b1;
        pins_d.lane  = cur_d.addr[DATA_W-1:0];
        pins_d.hi    = cur_d.addr[ADDR_W-1:DATA_W];
        pins_d.taken = start_d && req_valid;
        if (run_d) begin
            pins_d.as_p = (ph_d <= AS_END);
            pins_d.ds_p = (ph_d >= DS_BEG);
            pins_d.rw_p = !cur_d.write;
            pins_d.li_p = cur_d.fetch;
            if (ph_d <= ADR_END) begin
                pins_d.oe_p = 1'b1;
            end else if ((ph_d >= DS_BEG) && cur_d.write && !cur_d.internal) begin
                pins_d.oe_p = 1'b1;
                pins_d.lane = cur_d.wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q       <= '0;
            pins_q      <= '0;
            pins_q.rw_p <= 1'b1;
        end else begin
            cur_q  <= cur_d;
            pins_q <= pins_d;
        end
    end

    assign cap_fire = last_q && cur_q.live && !cur_q.write && !cur_q.internal;

    mbus_rdcap #(.DATA_W(DATA_W)) u_rdcap (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (cap_fire),
        .lane_in  (lane_in),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    assign bus_as    = pins_q.as_p;
    assign bus_ds    = pins_q.ds_p;
    assign bus_rw    = pins_q.rw_p;
    assign bus_li    = pins_q.li_p;
    assign lane_oe   = pins_q.oe_p;
    assign lane_out  = pins_q.lane;
    assign addr_hi   = pins_q.hi;
    assign req_taken = pins_q.taken;

endmodule

// File: rtl/mbus_seq_chk.sv
module mbus_seq_chk
    import mbus_pkg::*;
#(
    parameter int unsigned CYC_LEN  = 5,
    parameter int unsigned DS_FIRST = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_as,
    input logic              bus_ds,
    input logic              bus_rw,
    input logic              bus_li,
    input logic              lane_oe,
    input logic [DATA_W-1:0] lane_out,
    input logic [HI_W-1:0]   addr_hi,
    input logic              rd_valid,
    input logic              req_taken
);

    localparam int unsigned DS_LEN = CYC_LEN - DS_FIRST;

    int unsigned ds_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ds_cnt <= 0;
        end else begin
            ds_cnt <= bus_ds ? ds_cnt + 1 : 0;
        end
    end

    // R1
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_as && bus_ds));

    // R1
    ds_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_ds) |-> (ds_cnt == DS_LEN));

    // R2
    as_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_as |-> lane_oe);

    // R2
    as_fall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_as) |-> (lane_oe && $stable(lane_out)));

    // R4
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ds && bus_rw) |-> !lane_oe);

    // R4
    capture_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $fell(bus_ds));

    // R6
    ds_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ds |-> ($stable(addr_hi) && $stable(bus_rw)));

    // R7
    fetch_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_li |-> bus_rw);

    // R11
    taken_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_taken |-> $rose(bus_as));

endmodule

bind mbus_seq mbus_seq_chk #(
    .CYC_LEN  (CYC_LEN),
    .DS_FIRST (DS_FIRST)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_as    (bus_as),
    .bus_ds    (bus_ds),
    .bus_rw    (bus_rw),
    .bus_li    (bus_li),
    .lane_oe   (lane_oe),
    .lane_out  (lane_out),
    .addr_hi   (addr_hi),
    .rd_valid  (rd_valid),
    .req_taken (req_taken)
);

// File: tb/tb_mbus_seq.sv
module tb_mbus_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hold = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_fetch = 1'b0;
    logic        req_intr = 1'b0;
    logic        req_internal = 1'b0;
    logic [12:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  lane_in = '0;
    logic        req_taken, bus_as, bus_ds, bus_rw, bus_li, lane_oe, rd_valid;
    logic [7:0]  lane_out, rd_data;
    logic [4:0]  addr_hi;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] exp_rdata = '0;
    bit done = 0;

    always #5 clk = ~clk;

    mbus_seq dut (
        .clk(clk), .rst_n(rst_n), .hold(hold), .req_valid(req_valid),
        .req_write(req_write), .req_fetch(req_fetch), .req_intr(req_intr),
        .req_internal(req_internal), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_taken(req_taken), .bus_as(bus_as), .bus_ds(bus_ds), .bus_rw(bus_rw),
        .bus_li(bus_li), .lane_out(lane_out), .lane_oe(lane_oe), .lane_in(lane_in),
        .addr_hi(addr_hi), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Entry and exit: at the falling edge inside phase 0 of a running cycle.
    task automatic run_xfer(input bit w, input bit f, input bit irq, input bit intl,
                            input logic [12:0] a, input logic [7:0] wd, input logic [7:0] rin);
        bit exp_li, exp_oe_dp, exp_rd;
        exp_li    = f && !w && !irq;
        exp_oe_dp = w && !intl;
        exp_rd    = !w && !intl;
        req_valid = 1'b1; req_write = w; req_fetch = f; req_intr = irq;
        req_internal = intl; req_addr = a; req_wdata = wd; lane_in = 8'h00;
        @(negedge clk);
        check("R4 rd_valid one clock", rd_valid, 0);
        repeat (4) @(negedge clk);
        // phase 0 of the request's cycle
        check("R9 no capture after dummy", rd_valid, 0);
        check("R11 taken in phase 0", req_taken, 1);
        check("R1 as phase0", bus_as, 1);
        check("R1 ds phase0", bus_ds, 0);
        check("R2 oe phase0", lane_oe, 1);
        check("R2 lane addr phase0", lane_out, a[7:0]);
        check("R6 addr_hi", addr_hi, a[12:8]);
        check("R5 R3 rw", bus_rw, !w);
        check("R7 li", bus_li, exp_li);
        req_valid = 1'b0;
        @(negedge clk);
        check("R1 as phase1", bus_as, 1);
        check("R11 taken one clock", req_taken, 0);
        @(negedge clk);
        check("R1 as phase2", bus_as, 0);
        check("R2 oe phase2", lane_oe, 1);
        check("R2 lane addr phase2", lane_out, a[7:0]);
        lane_in = rin;
        for (int k = 3; k <= 4; k++) begin
            @(negedge clk);
            check("R1 ds data phase", bus_ds, 1);
            check("R1 as data phase", bus_as, 0);
            check("R3 R4 R8 lane oe data phase", lane_oe, exp_oe_dp);
            if (exp_oe_dp) check("R3 write data", lane_out, wd);
            check("R6 rw held", bus_rw, !w);
            check("R6 addr_hi held", addr_hi, a[12:8]);
            check("R7 li held", bus_li, exp_li);
        end
        @(negedge clk);
        // phase 0 of the following dummy cycle
        check("R4 R8 rd_valid", rd_valid, exp_rd);
        if (exp_rd) exp_rdata = rin;
        check("R4 R8 rd_data", rd_data, exp_rdata);
        check("R9 dummy as", bus_as, 1);
        check("R9 dummy rw", bus_rw, 1);
        check("R9 dummy taken", req_taken, 0);
        check("R9 dummy li", bus_li, 0);
        check("R9 dummy lane addr", lane_out, a[7:0]);
        check("R9 dummy addr_hi", addr_hi, a[12:8]);
    endtask

    task automatic check_parked(input int n);
        for (int k = 0; k < n; k++) begin
            check("R10 parked as", bus_as, 0);
            check("R10 parked ds", bus_ds, 0);
            check("R10 parked rw", bus_rw, 1);
            check("R10 parked oe", lane_oe, 0);
            check("R10 parked li", bus_li, 0);
            @(negedge clk);
        end
    endtask

    task automatic release_hold();
        hold = 1'b0;
        @(negedge clk);
        check("R10 restart phase 0", bus_as, 1);
        check("R10 restart dummy rw", bus_rw, 1);
        check("R10 restart no taken", req_taken, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12 as", bus_as, 0);
        check("R12 ds", bus_ds, 0);
        check("R12 rw", bus_rw, 1);
        check("R12 li", bus_li, 0);
        check("R12 oe", lane_oe, 0);
        check("R12 rd_valid", rd_valid, 0);
        check("R12 taken", req_taken, 0);
        rst_n = 1'b1;
        while (!bus_as) @(negedge clk);

        // Sweep every flag combination over two address/data patterns
        for (int i = 0; i < 32; i++) begin
            logic [12:0] a;
            logic [7:0]  wd, rin;
            a   = 13'((i * 829 + 37) ^ (1 << (i % 13)));
            wd  = 8'(i * 53 + 11);
            rin = 8'((i * 91) ^ 8'hA5);
            run_xfer(i[0], i[1], i[2], i[3], a, wd, rin);
        end

        // R10 hold raised in phase 0: the cycle completes, then the bus parks
        hold = 1'b1;
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            check("R10 cycle completes ds", bus_ds, (k >= 3) ? 1 : 0);
        end
        @(negedge clk);
        check_parked(4);
        release_hold();

        // R10 hold raised mid-cycle (phase 2)
        repeat (2) @(negedge clk);
        hold = 1'b1;
        @(negedge clk);
        check("R10 mid hold ds ph3", bus_ds, 1);
        @(negedge clk);
        check("R10 mid hold ds ph4", bus_ds, 1);
        @(negedge clk);
        check_parked(2);
        release_hold();

        // Transfers still work after parking
        run_xfer(1'b0, 1'b1, 1'b0, 1'b0, 13'h1FFF, 8'h00, 8'hFF);
        run_xfer(1'b1, 1'b0, 1'b0, 1'b0, 13'h0000, 8'hFF, 8'h00);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

endmodule